// File: doc/BRIEF.md
# Interleaved Bank Strided Load Scheduler

This block turns one strided vector load into a stream of single-element requests for a memory split into `N_BANKS` interleaved banks. A load is described by a starting element address, a stride counted in elements, and an element count. Element `i` lives at `base + i*stride`, taken modulo 2^ADDR_W. The bank that holds an address is selected by the low address bits.

Each bank stays occupied for `BUSY_CYC` cycles after it is accessed. The scheduler keeps one down-counter per bank. Requests go out strictly in element order, at most one per cycle. The head element waits while its bank is still occupied. Because of this, strides that revisit a bank sooner than `BUSY_CYC` cycles run at the bank rate instead of one element per cycle.

The memory answers every request exactly `LATENCY` cycles after it was issued. The scheduler tags each response with its element index, so results come out in element order. It also counts the cycles of the whole load, so the measured total can be compared with the expected one.

Top module: `strided_load_sched`

## Requirements
- R1: After reset, `busy_o`, `req_valid_o`, `out_valid_o` and `done_o` are low and `cycle_cnt_o` is zero.
- R2: The request for element i carries address `base_i + i*stride_i` (modulo 2^ADDR_W). Requests are issued in increasing element order, starting at index 0.
- R3: `req_bank_o` equals the low log2(N_BANKS) bits of `req_addr_o`. No bank receives a second request fewer than `BUSY_CYC` cycles after its previous one.
- R4: A request is issued in the earliest cycle that is both after the previous request and at least `BUSY_CYC` cycles after the last access to its bank. Element 0 goes out in the first cycle after the start is accepted, if its bank is free.
- R5: Each request produces exactly one `out_valid_o` cycle, `LATENCY` cycles after the request. That cycle carries the request's element index on `out_idx_o` and the memory word on `out_data_o`.
- R6: `done_o` is high only in the cycle that returns the last element. In that cycle `cycle_cnt_o` equals the number of cycles from the first request cycle through that cycle, both included. The counter then holds its value until the next load.
- R7: Default configuration (8 banks, busy time 6, latency 12), 64 elements: a unit stride takes 76 cycles, and a stride of 32 takes 12 + 1 + 6*63 = 391 cycles.
- R8: When `N_BANKS >= BUSY_CYC`, a unit-stride load issues its elements in consecutive cycles with no stall.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running load keeps its addresses, length and timing.
- R10: A `start_i` pulse with `len_i == 0` is ignored: no request is issued and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a load when idle and `len_i` is nonzero |
| base_i | input | ADDR_W | Element address of element 0 |
| stride_i | input | ADDR_W | Distance between elements, in elements |
| len_i | input | LEN_W | Number of elements |
| busy_o | output | 1 | A load is in progress |
| req_valid_o | output | 1 | Element request to memory this cycle |
| req_addr_o | output | ADDR_W | Element address of the request |
| req_bank_o | output | log2(N_BANKS) | Bank addressed by the request |
| rsp_data_i | input | DATA_W | Memory word, valid `LATENCY` cycles after its request |
| out_valid_o | output | 1 | Returned element valid |
| out_idx_o | output | LEN_W | Element index of the returned element |
| out_data_o | output | DATA_W | Returned element data |
| done_o | output | 1 | Last element is being returned |
| cycle_cnt_o | output | CNT_W | Cycle count of the current or last load |

## Verification
The first request cycle is the cycle right after the clock edge that accepts `start_i`. The issue cycle of every later element is predicted from a bank-free-time model of the greedy in-order schedule. Each returned element is due exactly `LATENCY` cycles after the cycle in which its request was seen. `done_o` and the final `cycle_cnt_o` are due in that same cycle for the last element. The bench numbers cycles from the first request cycle and samples on the falling edge, so each of these outputs is compared in the exact cycle it is due. A memory model in the bench returns words with the same fixed delay and flags any bank that is reused too early.

// File: rtl/sls_pkg.sv
package sls_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

endpackage

// File: rtl/sls_bank_tracker.sv
module sls_bank_tracker #(
  parameter int N_BANKS  = 8,
  parameter int BUSY_CYC = 6,
  localparam int BANK_W  = $clog2(N_BANKS),
  localparam int BUSY_W  = $clog2(BUSY_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [N_BANKS-1:0] busy_o
);

  localparam logic [BUSY_W-1:0] RELOAD = BUSY_W'(BUSY_CYC - 1);

  logic [N_BANKS-1:0] load_vec;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic [BUSY_W-1:0] cnt_q;

    assign load_vec[b] = fire_i && (bank_i == BANK_W'(b));
    assign busy_o[b]   = (cnt_q != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (load_vec[b])   cnt_q <= RELOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= RELOAD);
  end

  // R3
  one_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_vec));

  // R3
  free_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> !busy_o[bank_i]);

endmodule

// File: rtl/sls_addr_gen.sv
module sls_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [LEN_W-1:0]  last_idx_i,
  input  logic              stall_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  idx_o
);

  logic              active_q;
  logic [ADDR_W-1:0] addr_q, stride_q;
  logic [LEN_W-1:0]  idx_q;

  assign req_valid_o = active_q && !stall_i;
  assign addr_o      = addr_q;
  assign idx_o       = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      stride_q <= '0;
      idx_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      addr_q   <= base_i;
      stride_q <= stride_i;
      idx_q    <= '0;
    end else if (req_valid_o) begin
      if (idx_q == last_idx_i) begin
        active_q <= 1'b0;
      end else begin
        addr_q <= addr_q + stride_q;
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !load_i && (idx_q != last_idx_i)
      |=> (addr_q == $past(addr_q) + $past(stride_q)) && (idx_q == $past(idx_q) + 1'b1));

  // R4
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && stall_i && !load_i |=> $stable(addr_q) && $stable(idx_q));

endmodule

// File: rtl/sls_tag_pipe.sv
module sls_tag_pipe #(
  parameter int LEN_W   = 8,
  parameter int LATENCY = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [LEN_W-1:0] idx_i,
  output logic             vld_o,
  output logic [LEN_W-1:0] idx_o
);

  logic             vld_q [LATENCY];
  logic [LEN_W-1:0] idx_q [LATENCY];

  for (genvar s = 0; s < LATENCY; s++) begin : g_stage
    logic             vld_d;
    logic [LEN_W-1:0] idx_d;

    if (s == 0) begin : g_head
      assign vld_d = vld_i;
      assign idx_d = idx_i;
    end else begin : g_body
      assign vld_d = vld_q[s-1];
      assign idx_d = idx_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        idx_q[s] <= '0;
      end else begin
        vld_q[s] <= vld_d;
        idx_q[s] <= idx_d;
      end
    end
  end

  assign vld_o = vld_q[LATENCY-1];
  assign idx_o = idx_q[LATENCY-1];

endmodule

// File: rtl/strided_load_sched.sv
module strided_load_sched
  import sls_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 8,
  parameter int N_BANKS  = 8,
  parameter int BUSY_CYC = 6,
  parameter int LATENCY  = 12,
  parameter int CNT_W    = 16,
  localparam int BANK_W  = $clog2(N_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [BANK_W-1:0] req_bank_o,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              out_valid_o,
  output logic [LEN_W-1:0]  out_idx_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  cycle_cnt_o
);

  run_state_e         state_q;
  logic               accept, stall;
  logic [LEN_W-1:0]   last_q, req_idx;
  logic [N_BANKS-1:0] bank_busy;
  logic [CNT_W-1:0]   cyc_q;

  assign accept = start_i && (state_q == ST_IDLE) && (len_i != '0);
  assign busy_o = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      last_q  <= '0;
      cyc_q   <= '0;
    end else if (accept) begin
      state_q <= ST_RUN;
      last_q  <= len_i - 1'b1;
      cyc_q   <= CNT_W'(1);
    end else if (busy_o) begin
      if (done_o) state_q <= ST_IDLE;
      else        cyc_q   <= cyc_q + 1'b1;
    end
  end

  assign req_bank_o = req_addr_o[BANK_W-1:0];
  assign stall      = bank_busy[req_bank_o];

  sls_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_addr_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .base_i      (base_i),
    .stride_i    (stride_i),
    .last_idx_i  (last_q),
    .stall_i     (stall),
    .req_valid_o (req_valid_o),
    .addr_o      (req_addr_o),
    .idx_o       (req_idx)
  );

  sls_bank_tracker #(.N_BANKS(N_BANKS), .BUSY_CYC(BUSY_CYC)) i_bank_tracker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (req_valid_o),
    .bank_i (req_bank_o),
    .busy_o (bank_busy)
  );

  sls_tag_pipe #(.LEN_W(LEN_W), .LATENCY(LATENCY)) i_tag_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (req_valid_o),
    .idx_i  (req_idx),
    .vld_o  (out_valid_o),
    .idx_o  (out_idx_o)
  );

  assign out_data_o  = rsp_data_i;
  assign done_o      = out_valid_o && (out_idx_o == last_q);
  assign cycle_cnt_o = cyc_q;

  // R6
  done_in_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o && out_valid_o);

  // R6
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> cyc_q == $past(cyc_q) + 1'b1);

  // R6
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !accept |=> $stable(cyc_q));

  // R5
  ret_in_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> busy_o);

  // R9
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !done_o |=> busy_o && (last_q == $past(last_q)));

  // R10
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && (len_i == '0) |=> !busy_o);

endmodule

// File: tb/test_strided_load_sched.sv
`timescale 1ns/1ps
module test_strided_load_sched;

  localparam int ADDR_W = 32, DATA_W = 32, LEN_W = 8;
  localparam int NB = 8, BUSY = 6, LAT = 12, CNT_W = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [ADDR_W-1:0] base_i = '0, stride_i = '0;
  logic [LEN_W-1:0]  len_i = '0;
  logic busy_o, req_valid_o, out_valid_o, done_o;
  logic [ADDR_W-1:0] req_addr_o;
  logic [2:0]        req_bank_o;
  logic [DATA_W-1:0] rsp_data_i, out_data_o;
  logic [LEN_W-1:0]  out_idx_o;
  logic [CNT_W-1:0]  cycle_cnt_o;

  always #2 clk_i = ~clk_i;

  strided_load_sched #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .N_BANKS(NB),
    .BUSY_CYC(BUSY), .LATENCY(LAT), .CNT_W(CNT_W)
  ) i_strided_load_sched (
    .clk_i, .rst_ni, .start_i, .base_i, .stride_i, .len_i, .busy_o,
    .req_valid_o, .req_addr_o, .req_bank_o, .rsp_data_i, .out_valid_o,
    .out_idx_o, .out_data_o, .done_o, .cycle_cnt_o
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // banked memory model: fixed latency, flags early bank reuse
  logic [DATA_W-1:0] mpipe [LAT];
  longint tcyc = 0;
  longint last_use [NB];
  initial for (int b = 0; b < NB; b++) last_use[b] = -100;

  always @(posedge clk_i) begin
    tcyc <= tcyc + 1;
    mpipe[0] <= mem_word(req_addr_o);
    for (int s = 1; s < LAT; s++) mpipe[s] <= mpipe[s-1];
    if (rst_ni && req_valid_o) begin
      check(tcyc - last_use[req_addr_o[2:0]] >= BUSY, "R3 bank reuse gap",
            tcyc - last_use[req_addr_o[2:0]], BUSY);
      last_use[req_addr_o[2:0]] = tcyc;
    end
  end
  assign rsp_data_i = mpipe[LAT-1];

  int exp_t [256];

  function automatic int plan_load(logic [31:0] base, logic [31:0] stride, int len);
    int free_at [NB];
    int t = -1;
    for (int b = 0; b < NB; b++) free_at[b] = 0;
    for (int i = 0; i < len; i++) begin
      logic [31:0] a = base + i * stride;
      int bk = int'(a[2:0]);
      t = (t + 1 > free_at[bk]) ? t + 1 : free_at[bk];
      exp_t[i] = t;
      free_at[bk] = t + BUSY;
    end
    return t + LAT + 1;
  endfunction

  task automatic run_load(logic [31:0] base, logic [31:0] stride, int len,
                          bit poke, output int total);
    int exp_total, nreq, nout;
    logic [31:0] ea;
    exp_total = plan_load(base, stride, len);
    total = -1;
    nreq = 0; nout = 0;
    @(negedge clk_i);
    start_i = 1'b1; base_i = base; stride_i = stride; len_i = LEN_W'(len);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 5000; c++) begin
      if (poke && c == 3) begin
        start_i = 1'b1; base_i = base + 32'd5; stride_i = stride + 32'd3; len_i = 8'd2;
      end else begin
        start_i = 1'b0;
      end
      if (req_valid_o) begin
        ea = base + nreq * stride;
        check(req_addr_o == ea, "R2 addr", req_addr_o, ea);
        check(req_bank_o == ea[2:0], "R3 bank", req_bank_o, ea[2:0]);
        check(c == exp_t[nreq], "R4 issue cycle", c, exp_t[nreq]);
        nreq++;
      end
      if (out_valid_o) begin
        ea = base + nout * stride;
        check(out_idx_o == LEN_W'(nout), "R5 order", out_idx_o, nout);
        check(c == exp_t[nout] + LAT, "R5 latency", c, exp_t[nout] + LAT);
        check(out_data_o == mem_word(ea), "R5 data", out_data_o, mem_word(ea));
        nout++;
      end
      check(done_o == (nout == len && out_valid_o), "R6 done pulse", done_o, nout == len);
      if (done_o) begin
        check(cycle_cnt_o == CNT_W'(exp_total), "R6 cycle count", cycle_cnt_o, exp_total);
        check(nreq == len, poke ? "R9 request count" : "R6 request count", nreq, len);
        total = cycle_cnt_o;
        break;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    check(total >= 0, "R6 load finished", total, exp_total);
    repeat (3) @(negedge clk_i);
    check(cycle_cnt_o == CNT_W'(exp_total), "R6 count holds", cycle_cnt_o, exp_total);
    check(!busy_o, "R6 idle after", busy_o, 0);
    repeat (8) @(negedge clk_i);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      failures++; checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int tot;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // R1
    check(!busy_o && !req_valid_o && !out_valid_o && !done_o, "R1 outputs low",
          {busy_o, req_valid_o, out_valid_o, done_o}, 0);
    check(cycle_cnt_o == 0, "R1 counter", cycle_cnt_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R7 R8 unit stride
    run_load(32'd0, 32'd1, 64, 0, tot);
    check(tot == 76, "R7 unit stride total", tot, 76);
    check(exp_t[63] == 63, "R8 no stall", exp_t[63], 63);
    // R7 bank-multiple stride
    run_load(32'd0, 32'd32, 64, 0, tot);
    check(tot == 391, "R7 stride 32 total", tot, 391);
    // corner strides
    run_load(32'd3, 32'd2, 40, 0, tot);
    run_load(32'd7, 32'd0, 10, 0, tot);
    run_load(32'hFFFF_FFFC, 32'hFFFF_FFFF, 20, 0, tot);
    run_load(32'd100, 32'd1, 1, 0, tot);
    // R9 start while busy
    run_load(32'd64, 32'd3, 30, 1, tot);

    // R10 zero length
    @(negedge clk_i);
    start_i = 1'b1; len_i = '0; base_i = 32'd9; stride_i = 32'd1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(!busy_o && !req_valid_o, "R10 zero length ignored",
            {busy_o, req_valid_o}, 0);
      @(negedge clk_i);
    end

    for (int n = 0; n < 12; n++) begin
      run_load($urandom(), 32'($urandom_range(0, 40)), $urandom_range(1, 64), 0, tot);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule